// File: doc/BRIEF.md
# PLL Power-Up Sequencer with Lock Qualification

This block is a hardware state machine that owns the three control lines of an analog PLL: bypass release, active-low reset and output enable. It also drives a fourth observation bit. When an enable request rises, the sequencer first takes the PLL out of bypass and waits a fixed time. It then releases reset and lets the loop settle for a long window. After that it polls the lock indication once per microsecond. A lock is accepted only when it is seen on two samples taken one microsecond apart. Once lock is qualified, the output enable is switched on.

When the enable request is withdrawn, all four mode bits drop together in a single cycle. If lock never qualifies within the poll budget, the sequencer raises a timeout error and keeps the output off.

All waits are counted in reference clock ticks. A parameter gives the number of ticks per microsecond, so a simulation can run with small values. The mode bits are visible at all times as a four-bit view. A sticky flag records every lock sighting that vanished before it could be confirmed.

Top module: `pll_pwrup_seq`

## Requirements
- R1: Mode view encoding: bit 0 is output enable, bit 1 is bypass release (bypass is active when the bit is 0), bit 2 is reset release (reset is asserted when the bit is 0), and bit 3 is observation enable. After reset the mode view is 0000 and `done_o`, `timeout_o` and `early_lock_o` are all 0.
- R2: On an enable request, bits 1 and 3 rise first. Bit 2 rises exactly BYPASS_US × TICKS_PER_US cycles later.
- R3: No lock sample is taken during the SETTLE_US microseconds after bit 2 rises. A lock pulse inside that window has no effect on when the output turns on.
- R4: Lock is sampled once every TICKS_PER_US cycles, for at most MAX_POLLS samples. If the last sample finds no lock, `timeout_o` rises and bit 0 stays 0.
- R5: When lock is held throughout, the output turns on exactly SETTLE_US + 2 microseconds after bit 2 rises. This is one sample period to see lock plus one to confirm it.
- R6: Output enable is the last step. Bit 0 never rises unless bits 1 and 2 are already set. `done_o` is high exactly while the mode view reads 1111.
- R7: Withdrawing the enable request, from the locked or the timed-out state, clears all four mode bits and `done_o` in one cycle.
- R8: A lock seen on a poll but absent on the confirming sample sets `early_lock_o` and polling resumes. `early_lock_o` and `timeout_o` stay set until the next enable request starts a new sequence, where both are cleared.
- R9: A withdrawal of the enable request during power-up is deferred. The sequence completes, and the power-down takes place on the cycle after the sequence ends.
- R10: A lock first seen on the final poll is still confirmed. If the confirmation holds, the output turns on. If it fails, a timeout follows at that confirming sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Level request: 1 = PLL wanted on, 0 = off |
| pll_lock | input | 1 | Lock indication from the PLL |
| mode_o | output | 4 | Mode view: bit 0 output enable, bit 1 bypass release, bit 2 reset release, bit 3 observation enable |
| done_o | output | 1 | PLL running with output enabled |
| timeout_o | output | 1 | Lock never qualified within the poll budget (sticky) |
| early_lock_o | output | 1 | A lock sighting failed its confirmation (sticky) |

## Verification
The assertions check the following on every cycle:
- the output enable never runs ahead of the bypass and reset release bits;
- reset is released only after bypass was released;
- the timeout and the output enable are mutually exclusive;
- the power-down is a one-cycle, all-bits clear;
- a power-up in progress is never cut short.

The exact timing can only be shown by the bench scenarios, which drive lock patterns from a stub. These cover the bypass-to-reset spacing, the settle window ignoring a transient lock, double-sample qualification, a glitch that sets the early-lock flag, the poll budget ending in a timeout, and a lock found on the final poll. Flag clearing on a new enable, and the deferred power-down, are also shown only there.

// File: rtl/pll_pwrup_seq.sv
module pll_pwrup_seq #(
  parameter int TICKS_PER_US = 19,
  parameter int BYPASS_US    = 10,
  parameter int SETTLE_US    = 200,
  parameter int MAX_POLLS    = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_req,
  input  logic       pll_lock,
  output logic [3:0] mode_o,
  output logic       done_o,
  output logic       timeout_o,
  output logic       early_lock_o
);
  localparam int US_CYC  = TICKS_PER_US;
  localparam int BYP_CYC = BYPASS_US * TICKS_PER_US;
  localparam int SET_CYC = SETTLE_US * TICKS_PER_US;
  localparam int LONGEST = (SET_CYC > BYP_CYC) ? SET_CYC : BYP_CYC;
  localparam int CW      = $clog2(LONGEST + 1);
  localparam int PW      = $clog2(MAX_POLLS + 1);

  typedef enum logic [2:0] {S_OFF, S_BYP, S_SETTLE, S_POLL, S_CONFIRM, S_ON, S_FAIL} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pcnt;
  logic [3:0]    mode_q;
  logic          tmo_q, early_q;

  wire us_end = (cnt == CW'(US_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_OFF;
      cnt     <= '0;
      pcnt    <= '0;
      mode_q  <= 4'b0000;
      tmo_q   <= 1'b0;
      early_q <= 1'b0;
    end else begin
      case (st)
        S_OFF: if (en_req) begin
          st      <= S_BYP;
          mode_q  <= 4'b1010;
          cnt     <= '0;
          tmo_q   <= 1'b0;
          early_q <= 1'b0;
        end
        S_BYP: if (cnt == CW'(BYP_CYC - 1)) begin
          st        <= S_SETTLE;
          mode_q[2] <= 1'b1;
          cnt       <= '0;
        end else cnt <= cnt + 1'b1;
        S_SETTLE: if (cnt == CW'(SET_CYC - 1)) begin
          st   <= S_POLL;
          cnt  <= '0;
          pcnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_POLL: if (us_end) begin
          cnt  <= '0;
          pcnt <= pcnt + 1'b1;
          if (pll_lock) st <= S_CONFIRM;
          else if (pcnt == PW'(MAX_POLLS - 1)) begin
            st    <= S_FAIL;
            tmo_q <= 1'b1;
          end
        end else cnt <= cnt + 1'b1;
        S_CONFIRM: if (us_end) begin
          cnt <= '0;
          if (pll_lock) begin
            st        <= S_ON;
            mode_q[0] <= 1'b1;
          end else begin
            early_q <= 1'b1;
            if (pcnt == PW'(MAX_POLLS)) begin
              st    <= S_FAIL;
              tmo_q <= 1'b1;
            end else st <= S_POLL;
          end
        end else cnt <= cnt + 1'b1;
        S_ON, S_FAIL: if (!en_req) begin
          st     <= S_OFF;
          mode_q <= 4'b0000;
        end
        default: st <= S_OFF;
      endcase
    end
  end

  assign mode_o       = mode_q;
  assign done_o       = (st == S_ON);
  assign timeout_o    = tmo_q;
  assign early_lock_o = early_q;

  wire busy = (st == S_BYP) || (st == S_SETTLE) || (st == S_POLL) || (st == S_CONFIRM);

  p_out_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o[0] |-> (mode_o[1] && mode_o[2]));

  p_done_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (mode_o == 4'b1111));

  p_bypass_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_o[2]) |-> ($past(mode_o[1]) && mode_o[1]));

  p_tmo_no_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !mode_o[0]);

  p_onestep_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_o || timeout_o) && !busy && st != S_OFF && !en_req) |=> (mode_o == 4'b0000 && !done_o));

  p_deferred_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (st != S_OFF));

  p_poll_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL) |-> (pcnt < PW'(MAX_POLLS)));
endmodule

// File: tb/pll_pwrup_seq_tb.sv
`timescale 1ns/1ps
module pll_pwrup_seq_tb_top;
  localparam int TPU  = 2;
  localparam int BYPU = 10;
  localparam int SETU = 200;
  localparam int NPOL = 200;
  localparam int SETC = SETU * TPU;
  localparam int NSC  = 6;

  // scenario: lock pattern, expected delay from reset release, success, early flag
  localparam int EXP_DLY [NSC] = '{SETC + 2*TPU, SETC + NPOL*TPU, SETC + 4*TPU,
                                   SETC + 4*TPU, SETC + (NPOL+1)*TPU, SETC + (NPOL+1)*TPU};
  localparam bit EXP_OK  [NSC] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam bit EXP_ERL [NSC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, en_req = 1'b0, pll_lock;
  logic [3:0] mode_o;
  logic done_o, timeout_o, early_lock_o;
  int scen = 0, ccnt = 0, cyc = 0;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pll_pwrup_seq #(.TICKS_PER_US(TPU), .BYPASS_US(BYPU), .SETTLE_US(SETU), .MAX_POLLS(NPOL)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .pll_lock(pll_lock),
    .mode_o(mode_o), .done_o(done_o), .timeout_o(timeout_o), .early_lock_o(early_lock_o));

  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    ccnt <= mode_o[2] ? ccnt + 1 : 0;
  end

  always_comb begin
    case (scen)
      0: pll_lock = 1'b1;
      1: pll_lock = 1'b0;
      2: pll_lock = (ccnt >= 30 && ccnt < 40) || (ccnt >= SETC + 3*TPU - 1);
      3: pll_lock = (ccnt == SETC + TPU - 1) || (ccnt >= SETC + 3*TPU - 1);
      4: pll_lock = (ccnt >= SETC + NPOL*TPU - 1);
      5: pll_lock = (ccnt == SETC + NPOL*TPU - 1);
      default: pll_lock = 1'b1;
    endcase
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int t1, t2, t3;
    repeat (3) @(negedge clk);
    chk(mode_o == 4'b0000, "R1 mode after reset", mode_o, 0);
    chk(!done_o && !timeout_o && !early_lock_o, "R1 flags after reset",
        {done_o, timeout_o, early_lock_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < NSC; s++) begin
      scen = s;
      en_req = 1'b1;
      t1 = -1; t2 = -1; t3 = -1;
      for (int k = 0; k < 4000 && t3 < 0; k++) begin
        @(negedge clk);
        if (t1 < 0 && mode_o[1]) begin
          t1 = cyc;
          chk(mode_o == 4'b1010, "R2 first step bits", mode_o, 4'b1010);
          chk(!early_lock_o && !timeout_o, "R8 flags cleared on enable",
              {timeout_o, early_lock_o}, 0);
        end
        if (t2 < 0 && mode_o[2]) t2 = cyc;
        if (done_o || timeout_o) t3 = cyc;
      end
      chk(t2 - t1 == BYPU * TPU, "R2 bypass to reset spacing", t2 - t1, BYPU * TPU);
      chk(t3 - t2 == EXP_DLY[s], (s == 0) ? "R5 qualified lock time" :
          (s == 1) ? "R4 timeout time" : (s == 2) ? "R3 settle ignores transient" :
          (s == 3) ? "R8 glitch then lock" : "R10 final poll", t3 - t2, EXP_DLY[s]);
      chk(done_o == EXP_OK[s], "R4 outcome", done_o, EXP_OK[s]);
      chk(mode_o == (EXP_OK[s] ? 4'b1111 : 4'b1110), "R6 mode at end", mode_o,
          EXP_OK[s] ? 4'b1111 : 4'b1110);
      chk(early_lock_o == EXP_ERL[s], "R8 early flag", early_lock_o, EXP_ERL[s]);
      en_req = 1'b0;
      @(negedge clk);
      chk(mode_o == 4'b0000 && !done_o, "R7 one-step power-down", mode_o, 0);
      chk(timeout_o == !EXP_OK[s] && early_lock_o == EXP_ERL[s], "R8 flags sticky after off",
          {timeout_o, early_lock_o}, {!EXP_OK[s], EXP_ERL[s]});
      repeat (2) @(negedge clk);
    end

    scen = 0;
    en_req = 1'b1;
    repeat (BYPU * TPU + 5) @(negedge clk);
    en_req = 1'b0;
    chk(mode_o == 4'b1110, "R9 still powering up", mode_o, 4'b1110);
    t3 = -1;
    for (int k = 0; k < 2000 && t3 < 0; k++) begin
      @(negedge clk);
      if (mode_o != 4'b1110) t3 = cyc;
    end
    chk(done_o && mode_o == 4'b1111, "R9 sequence completes", mode_o, 4'b1111);
    @(negedge clk);
    chk(mode_o == 4'b0000 && !done_o, "R9 deferred power-down", mode_o, 0);
    finish_run();
  end
endmodule